// File: doc/BRIEF.md
# Calibration Command and EEPROM Sequencer

This block sits behind a narrow register-access port and turns nibble-wide writes into EEPROM and calibration operations. A host fills a data holding byte and a 10-bit EEPROM address a nibble at a time. It sets two small pointers, one for a calibration register and one for a readback source. It then writes a 4-bit code into the command slot. The code starts one of several operations:
- a byte program into the EEPROM array, which is modelled as registers;
- a full or page erase;
- a copy of the data byte into a calibration register;
- a readback of an internal value onto a byte output.

Programming can only clear bits: the new byte is the bitwise AND of the old contents and the data byte, so only a byte erased to 0xFF can take any value. After every erase the block stays busy for a fixed number of cycles (6 ms of clock time by default). During that window it ignores all commands that would touch the array or the calibration registers. Readback stays available during the window, so the host can poll the busy status.

Top module: `cal_cmd_seq`

## Requirements
- R1: After reset the following hold:
  - `busy` = 0, `rb_valid` = 0, `rb_byte` = 0x00;
  - the data byte, the address and both pointers are 0;
  - every EEPROM byte is 0xFF;
  - all eight calibration registers are 0x00.
- R2: A write to slot 0 replaces data bits [3:0]. A write to slot 1 replaces data bits [7:4]. Each leaves the other nibble unchanged.
- R3: Writes to slots 2, 3 and 4 replace address bits [3:0], [7:4] and [9:8]. Slot 4 takes `acc_nib[1:0]`. Each slot leaves the other address bits unchanged.
- R4: Command code 4 (program) sets the EEPROM byte at the current address to its old value AND the data byte.
- R5: Command code 2 (full erase) sets every EEPROM byte to 0xFF and starts the busy window.
- R6: Command code 3 (page erase) has these effects:
  - it sets to 0xFF the 16 bytes whose address bits [9:4] equal those of the current address;
  - it leaves every other byte unchanged;
  - it starts the busy window.
- R7: `busy` is high for exactly BUSY_CYCLES clock cycles, counted from the edge that accepts an erase command.
- R8: While `busy` is high, codes 1, 2, 3 and 4 have no effect. Nibble writes to slots 0 to 6 are still accepted.
- R9: Command code 1 copies the data byte into calibration register n, where n is the calibration pointer (slot 5). Pointer values 8 to 15 load nothing.
- R10: Command code 5, even while busy, causes the following one cycle later:
  - `rb_valid` pulses high for one cycle;
  - `rb_byte` shows the source chosen by the readback pointer (slot 6), per the table below.

  | Pointer | Source |
  |---|---|
  | 0 | data byte |
  | 1 | address [7:0] |
  | 2 | address [9:8] in bits [1:0], zero above |
  | 3 | busy in bit 0, zero above |
  | 4 | EEPROM byte at the address |
  | 5 to 7 | 0x00 |
  | 8 to 15 | calibration register (pointer − 8) |
- R11: Codes 0 and 6 to 15 change no EEPROM byte, calibration register or busy state, and do not pulse `rb_valid`. Slot 7 is the command slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register access strobe, one write per cycle |
| acc_idx | input | 3 | Register slot (0..4 data/address nibbles, 5 cal pointer, 6 readback pointer, 7 command) |
| acc_nib | input | 4 | Nibble written to the slot |
| busy | output | 1 | Post-erase busy window active |
| rb_valid | output | 1 | One-cycle pulse when `rb_byte` is refreshed |
| rb_byte | output | 8 | Readback byte |

## Verification
The assertions take for granted that the access port delivers at most one write per cycle, so the address cannot change in the cycle that follows a program command. The write-merge property depends on this. They also assume that reset is held for at least one clock edge before the first access. The bench drives every access from a single task that raises `acc_wr` for exactly one cycle, which keeps both assumptions true. Its random addresses are drawn from four pages, so programs, page erases and readbacks often land on the same bytes.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam int EE_ADDR_W   = 10;
  localparam int EE_PAGE_W   = 4;
  localparam int NUM_CAL     = 8;

  // Register slots of the access port.
  localparam logic [2:0] SLOT_DATA_LO = 3'd0;
  localparam logic [2:0] SLOT_DATA_HI = 3'd1;
  localparam logic [2:0] SLOT_ADDR0   = 3'd2;
  localparam logic [2:0] SLOT_CALPTR  = 3'd5;
  localparam logic [2:0] SLOT_RBPTR   = 3'd6;
  localparam logic [2:0] SLOT_CMD     = 3'd7;

  // Command codes.
  localparam logic [3:0] CMD_LOADCAL    = 4'd1;
  localparam logic [3:0] CMD_ERASE_ALL  = 4'd2;
  localparam logic [3:0] CMD_ERASE_PAGE = 4'd3;
  localparam logic [3:0] CMD_PROGRAM    = 4'd4;
  localparam logic [3:0] CMD_READBACK   = 4'd5;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Programming may only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Pointer 8..15 selects a calibration register for readback.
  function automatic logic ptr_is_cal(input logic [3:0] p);
    return p[3];
  endfunction
endpackage

// File: rtl/cal_access_regs.sv
module cal_access_regs
  import cal_seq_pkg::*;
#(
  parameter int ADDR_W = EE_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic [2:0]        acc_idx,
  input  logic [3:0]        acc_nib,
  output logic [7:0]        data_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [3:0]        calptr_q,
  output logic [3:0]        rbptr_q,
  output logic              cmd_strobe,
  output logic [3:0]        cmd_code
);
  localparam int ADDR_NIB = (ADDR_W + 3) / 4;

  // Data holding byte, two nibble slots.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (acc_wr && acc_idx == SLOT_DATA_LO) begin
      data_q[3:0] <= acc_nib;
    end else if (acc_wr && acc_idx == SLOT_DATA_HI) begin
      data_q[7:4] <= acc_nib;
    end
  end

  // Address, one slot per nibble; the last one may be narrower.
  for (genvar k = 0; k < ADDR_NIB; k++) begin : g_addr_nib
    localparam int LO = 4 * k;
    localparam int W  = (ADDR_W - LO) < 4 ? (ADDR_W - LO) : 4;
    localparam logic [2:0] SLOT = 3'(SLOT_ADDR0 + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[LO +: W] <= '0;
      end else if (acc_wr && acc_idx == SLOT) begin
        addr_q[LO +: W] <= acc_nib[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calptr_q <= '0;
      rbptr_q  <= '0;
    end else if (acc_wr) begin
      if (acc_idx == SLOT_CALPTR) calptr_q <= acc_nib;
      if (acc_idx == SLOT_RBPTR)  rbptr_q  <= acc_nib;
    end
  end

  assign cmd_strobe = acc_wr && (acc_idx == SLOT_CMD);
  assign cmd_code   = acc_nib;
endmodule

// File: rtl/cal_cmd_decode.sv
module cal_cmd_decode
  import cal_seq_pkg::*;
(
  input  logic       cmd_strobe,
  input  logic [3:0] cmd_code,
  input  logic       busy,
  output logic       do_loadcal,
  output logic       do_erase_all,
  output logic       do_erase_page,
  output logic       do_program,
  output logic       do_readback
);
  logic gate;
  assign gate = cmd_strobe && !busy;

  always_comb begin
    do_loadcal    = 1'b0;
    do_erase_all  = 1'b0;
    do_erase_page = 1'b0;
    do_program    = 1'b0;
    do_readback   = 1'b0;
    if (cmd_strobe) begin
      unique case (cmd_code)
        CMD_LOADCAL:    do_loadcal    = gate;
        CMD_ERASE_ALL:  do_erase_all  = gate;
        CMD_ERASE_PAGE: do_erase_page = gate;
        CMD_PROGRAM:    do_program    = gate;
        CMD_READBACK:   do_readback   = 1'b1;
        default:        ;
      endcase
    end
  end
endmodule

// File: rtl/cal_busy_timer.sv
module cal_busy_timer #(
  parameter int BUSY_CYCLES = 300_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/cal_ee_array.sv
module cal_ee_array
  import cal_seq_pkg::*;
#(
  parameter int ADDR_W = EE_ADDR_W,
  parameter int PAGE_W = EE_PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_all,
  input  logic              erase_page,
  input  logic              program_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  function automatic logic same_page(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return (a >> PAGE_W) == (b >> PAGE_W);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (erase_all) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (erase_page) begin
      for (int i = 0; i < DEPTH; i++)
        if (same_page(ADDR_W'(i), addr)) mem[i] <= ERASED_BYTE;
    end else if (program_en) begin
      mem[addr] <= prog_merge(mem[addr], wdata);
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/cal_cmd_seq.sv
module cal_cmd_seq
  import cal_seq_pkg::*;
#(
  parameter int ADDR_W      = EE_ADDR_W,
  parameter int PAGE_W      = EE_PAGE_W,
  parameter int BUSY_CYCLES = 300_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic [2:0] acc_idx,
  input  logic [3:0] acc_nib,
  output logic       busy,
  output logic       rb_valid,
  output logic [7:0] rb_byte
);
  localparam int CAL_W = $clog2(NUM_CAL);

  logic [7:0]        data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        calptr_q, rbptr_q;
  logic              cmd_strobe;
  logic [3:0]        cmd_code;
  logic              do_loadcal, do_erase_all, do_erase_page, do_program, do_readback;
  logic              erase_fire;
  logic [7:0]        ee_q;
  logic [7:0]        cal_q [NUM_CAL];
  logic [7:0]        rb_src;

  cal_access_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_nib(acc_nib),
    .data_q(data_q), .addr_q(addr_q), .calptr_q(calptr_q), .rbptr_q(rbptr_q),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code)
  );

  cal_cmd_decode u_dec (
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .busy(busy),
    .do_loadcal(do_loadcal), .do_erase_all(do_erase_all), .do_erase_page(do_erase_page),
    .do_program(do_program), .do_readback(do_readback)
  );

  assign erase_fire = do_erase_all || do_erase_page;

  cal_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(erase_fire), .busy(busy)
  );

  cal_ee_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ee (
    .clk(clk), .rst_n(rst_n), .erase_all(do_erase_all), .erase_page(do_erase_page),
    .program_en(do_program), .addr(addr_q), .wdata(data_q), .rdata(ee_q)
  );

  // Calibration registers, loaded only from an in-range pointer.
  for (genvar c = 0; c < NUM_CAL; c++) begin : g_cal
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cal_q[c] <= '0;
      else if (do_loadcal && calptr_q == 4'(c)) cal_q[c] <= data_q;
    end
  end

  always_comb begin
    rb_src = '0;
    if (ptr_is_cal(rbptr_q)) begin
      rb_src = cal_q[rbptr_q[CAL_W-1:0]];
    end else begin
      case (rbptr_q[2:0])
        3'd0:    rb_src = data_q;
        3'd1:    rb_src = addr_q[7:0];
        3'd2:    rb_src = 8'(addr_q >> 8);
        3'd3:    rb_src = {7'b0, busy};
        3'd4:    rb_src = ee_q;
        default: rb_src = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_valid <= 1'b0;
      rb_byte  <= '0;
    end else begin
      rb_valid <= do_readback;
      if (do_readback) rb_byte <= rb_src;
    end
  end
endmodule

// File: rtl/cal_seq_checker.sv
module cal_seq_checker #(
  parameter int BUSY_CYCLES = 300_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rb_valid,
  input logic [7:0] ee_q,
  input logic [7:0] data_q,
  input logic       do_loadcal,
  input logic       do_erase_all,
  input logic       do_erase_page,
  input logic       do_program,
  input logic       do_readback
);
  logic [31:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           win_cnt <= '0;
    else if (do_erase_all || do_erase_page) win_cnt <= 32'(BUSY_CYCLES);
    else if (win_cnt != 0)                win_cnt <= win_cnt - 1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !rb_valid));

  p_program_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_program |=> ee_q == ($past(ee_q) & $past(data_q)));

  p_erase_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_erase_all || do_erase_page) |=> busy);

  p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (win_cnt != 0));

  p_ignore_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(do_loadcal || do_erase_all || do_erase_page || do_program));

  p_rb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    do_readback |=> rb_valid);

  p_rb_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !do_readback |=> !rb_valid);

  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_loadcal, do_erase_all, do_erase_page, do_program, do_readback}));
endmodule

bind cal_cmd_seq cal_seq_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rb_valid(rb_valid), .ee_q(ee_q),
  .data_q(data_q), .do_loadcal(do_loadcal), .do_erase_all(do_erase_all),
  .do_erase_page(do_erase_page), .do_program(do_program), .do_readback(do_readback)
);

// File: tb/test_cal_cmd_seq.sv
module test_cal_cmd_seq;
  localparam int N_BUSY = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_wr = 1'b0;
  logic [2:0] acc_idx = '0;
  logic [3:0] acc_nib = '0;
  logic       busy, rb_valid;
  logic [7:0] rb_byte;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] m_mem [1024];
  logic [7:0] m_cal [8];
  logic [7:0] m_data;
  logic [9:0] m_addr;

  cal_cmd_seq #(.BUSY_CYCLES(N_BUSY)) i_cal_cmd_seq (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_idx(acc_idx), .acc_nib(acc_nib),
    .busy(busy), .rb_valid(rb_valid), .rb_byte(rb_byte)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete (got timeout, expected end)");
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One access; called and returns at a falling edge.
  task automatic acc(input logic [2:0] idx, input logic [3:0] nib);
    acc_wr = 1'b1; acc_idx = idx; acc_nib = nib;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic set_data(input logic [7:0] d);
    acc(3'd0, d[3:0]); acc(3'd1, d[7:4]); m_data = d;
  endtask

  task automatic set_addr(input logic [9:0] a);
    acc(3'd2, a[3:0]); acc(3'd3, a[7:4]); acc(3'd4, {2'b00, a[9:8]}); m_addr = a;
  endtask

  function automatic logic [7:0] exp_rb(input logic [3:0] s, input logic b);
    if (s[3]) return m_cal[s[2:0]];
    case (s[2:0])
      3'd0: return m_data;
      3'd1: return m_addr[7:0];
      3'd2: return {6'b0, m_addr[9:8]};
      3'd3: return {7'b0, b};
      3'd4: return m_mem[m_addr];
      default: return 8'h00;
    endcase
  endfunction

  // Readback: rb_valid and rb_byte are set by the edge the task waits through.
  task automatic rb_check(input string req, input logic [3:0] s, input logic b);
    acc(3'd6, s);
    acc(3'd7, 4'd5);
    chk({req, " rb_valid"}, rb_valid, 1'b1);
    chk(req, rb_byte, exp_rb(s, b));
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_page_erase();
    acc(3'd7, 4'd3);
    for (int i = 0; i < 1024; i++)
      if (i[9:4] == m_addr[9:4]) m_mem[i] = 8'hFF;
    wait_idle();
  endtask

  function automatic logic [9:0] pick_addr();
    logic [5:0] pg [4] = '{6'h00, 6'h01, 6'h20, 6'h3F};
    return {pg[$urandom_range(0, 3)], 4'($urandom_range(0, 15))};
  endfunction

  initial begin
    void'($urandom(32'h1452));
    for (int i = 0; i < 1024; i++) m_mem[i] = 8'hFF;
    for (int i = 0; i < 8; i++) m_cal[i] = 8'h00;
    m_data = 8'h00; m_addr = 10'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 rb_valid", rb_valid, 1'b0);
    chk("R1 rb_byte", rb_byte, 8'h00);
    rb_check("R1 data", 4'd0, 1'b0);
    rb_check("R1 eeprom 0", 4'd4, 1'b0);
    rb_check("R1 cal 3", 4'd11, 1'b0);
    @(negedge clk);
    chk("R10 rb_valid drops", rb_valid, 1'b0);

    // R2 nibble assembly of the data byte
    set_data(8'hA5);
    rb_check("R2 data both", 4'd0, 1'b0);
    acc(3'd1, 4'h3); m_data[7:4] = 4'h3;
    rb_check("R2 high only", 4'd0, 1'b0);
    acc(3'd0, 4'hC); m_data[3:0] = 4'hC;
    rb_check("R2 low only", 4'd0, 1'b0);

    // R3 address assembly
    set_addr(10'h2B7);
    rb_check("R3 addr low", 4'd1, 1'b0);
    rb_check("R3 addr high", 4'd2, 1'b0);
    acc(3'd4, 4'hE); m_addr[9:8] = 2'b10;
    rb_check("R3 top slot uses nib[1:0]", 4'd2, 1'b0);
    acc(3'd3, 4'h1); m_addr[7:4] = 4'h1;
    rb_check("R3 middle slot only", 4'd1, 1'b0);

    // R4 program is an AND into the byte
    set_addr(10'h013); set_data(8'h3C);
    acc(3'd7, 4'd4); m_mem[m_addr] = m_mem[m_addr] & m_data;
    rb_check("R4 program erased byte", 4'd4, 1'b0);
    set_data(8'hF0);
    acc(3'd7, 4'd4); m_mem[m_addr] = m_mem[m_addr] & m_data;
    rb_check("R4 reprogram cannot set bits", 4'd4, 1'b0);

    // R9 calibration load and out-of-range pointer
    set_data(8'h5A); acc(3'd5, 4'd6);
    acc(3'd7, 4'd1); m_cal[6] = m_data;
    rb_check("R9 load cal 6", 4'd14, 1'b0);
    set_data(8'h77); acc(3'd5, 4'd9);
    acc(3'd7, 4'd1);
    for (int c = 0; c < 8; c++) rb_check("R9 pointer 9 loads nothing", 4'(8 + c), 1'b0);

    // R11 unused codes have no effect
    acc(3'd7, 4'd0); acc(3'd7, 4'd6); acc(3'd7, 4'd15);
    chk("R11 no rb pulse", rb_valid, 1'b0);
    chk("R11 not busy", busy, 1'b0);
    rb_check("R11 eeprom kept", 4'd4, 1'b0);
    rb_check("R11 cal kept", 4'd14, 1'b0);

    // R6 + R7 page erase and busy length
    set_addr(10'h01A); set_data(8'h00);
    acc(3'd7, 4'd4); m_mem[m_addr] = 8'h00;
    set_addr(10'h02A);
    acc(3'd7, 4'd4); m_mem[m_addr] = 8'h00;
    set_addr(10'h015);
    acc(3'd7, 4'd3);
    begin
      int n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk("R7 busy length", 32'(n), 32'(N_BUSY));
    end
    for (int i = 0; i < 1024; i++) if (i[9:4] == 6'h01) m_mem[i] = 8'hFF;
    set_addr(10'h01A);
    rb_check("R6 page byte erased", 4'd4, 1'b0);
    set_addr(10'h013);
    rb_check("R6 page byte 13 erased", 4'd4, 1'b0);
    set_addr(10'h02A);
    rb_check("R6 other page kept", 4'd4, 1'b0);

    // R8 commands ignored while busy, nibble writes accepted
    set_data(8'h11); acc(3'd5, 4'd2);
    set_addr(10'h040);
    acc(3'd7, 4'd3);
    for (int i = 0; i < 1024; i++) if (i[9:4] == 6'h04) m_mem[i] = 8'hFF;
    set_addr(10'h02A);
    set_data(8'hFF);
    acc(3'd7, 4'd1);
    acc(3'd7, 4'd2);
    acc(3'd0, 4'h0); m_data[3:0] = 4'h0;
    acc(3'd7, 4'd4);
    chk("R8 still busy", busy, 1'b1);
    rb_check("R10 status while busy", 4'd3, 1'b1);
    rb_check("R8 data nibble while busy", 4'd0, 1'b1);
    wait_idle();
    rb_check("R8 program ignored", 4'd4, 1'b0);
    rb_check("R8 load ignored", 4'd10, 1'b0);

    // R5 full erase
    acc(3'd7, 4'd2);
    chk("R5 busy after erase", busy, 1'b1);
    for (int i = 0; i < 1024; i++) m_mem[i] = 8'hFF;
    wait_idle();
    rb_check("R5 byte erased", 4'd4, 1'b0);
    set_addr(10'h013);
    rb_check("R5 byte 13 erased", 4'd4, 1'b0);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 5))
        0: set_data(8'($urandom));
        1: set_addr(pick_addr());
        2: begin acc(3'd7, 4'd4); m_mem[m_addr] = m_mem[m_addr] & m_data; end
        3: rb_check("R4 random eeprom", 4'd4, 1'b0);
        4: begin
             logic [3:0] p = 4'($urandom_range(0, 7));
             acc(3'd5, p); acc(3'd7, 4'd1); m_cal[p[2:0]] = m_data;
             rb_check("R9 random cal", 4'(8 + p), 1'b0);
           end
        default: if ($urandom_range(0, 3) == 0) do_page_erase();
      endcase
    end

    done = 1;
    finish_run();
  end
endmodule